// File: doc/BRIEF.md
# Dual Byte-Lane Hamming Codec

This block provides the error-correction logic for a 16-bit memory that is split into two independent byte lanes. On the write side, each 8-bit lane of the write word is encoded into 4 check bits, so the memory stores 12 bits per lane. On the read side, each stored 12-bit lane codeword is checked. A single flipped bit in a lane is repaired before the data leaves the codec, and each lane reports its own syndrome and status flags. The check bits exist only between the codec and the storage array. The user sees plain 16-bit data.

The two lanes share no logic state. A lane has its own code, so one error in each lane is corrected at the same time. Within a 12-bit lane codeword, the check bits occupy positions 1, 2, 4 and 8. The data bits fill positions 3, 5, 6, 7, 9, 10, 11 and 12, with data bit 0 at position 3 and the rest following in ascending order. The codec is combinational. An output register is selected by a parameter and is on by default.

Top module: `bytelane_secc`

## Requirements
- R1: Check bit k of a lane (k = 0..3, on `wr_chk[4*lane+k]`) is the XOR of the lane's data bits whose codeword position has bit k set. Data bit i sits at position 3, 5, 6, 7, 9, 10, 11, 12 for i = 0..7.
- R2: A lane whose stored data and check bits agree reports syndrome 0 and clears both of its flags. Its data passes through unchanged.
- R3: When exactly one stored data bit of a lane is flipped, the lane returns the original byte, raises its corrected flag and reports the 1-based position of that bit as its syndrome.
- R4: When exactly one stored check bit of a lane is flipped, the lane's data passes unchanged. The corrected flag rises and the syndrome is 1, 2, 4 or 8.
- R5: The lanes are independent. One single-bit error in each lane is corrected at the same time, and an error in one lane leaves the other lane's data, syndrome and flags unaffected.
- R6: A syndrome of 13, 14 or 15 raises the lane's uncorrectable flag and clears its corrected flag. The stored data passes through unmodified.
- R7: With the output register enabled (default), every output shows the result for the inputs present at the previous rising clock edge. While reset is low, all outputs are zero.
- R8: In each lane, the corrected and uncorrectable flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| wr_data | input | 16 | Data word to encode; lane L is bits 8L+7..8L |
| wr_chk | output | 8 | Check bits for storage; lane L is bits 4L+3..4L |
| rd_data | input | 16 | Stored data bits read back from the array |
| rd_chk | input | 8 | Stored check bits read back from the array |
| rd_fixed | output | 16 | Corrected read data |
| rd_syn | output | 8 | Per-lane syndrome; lane L is bits 4L+3..4L |
| rd_corr | output | 2 | Per-lane flag: a single error was located (data or check bit) |
| rd_uncorr | output | 2 | Per-lane flag: syndrome points beyond position 12 |

## Verification
The hardest case to reach is a syndrome of 13, 14 or 15, because no single flipped bit ever produces one. The bench reaches these values by XORing chosen patterns into several check bits of a correctly encoded lane. A second case that is hard to reach is a single error in each lane in the same cycle. The bench builds these by corrupting one data position in one lane and one check position in the other, using its own model of the position layout. It then confirms that neither lane's result leaks into the other.

// File: rtl/bls_pkg.sv
package bls_pkg;

   // 1 when v is a power of two (check-bit position)
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // 1-based codeword position of data bit idx: positions that are not
   // powers of two, taken in ascending order
   function automatic int data_pos(input int idx);
      int p;
      int seen;
      p    = 0;
      seen = -1;
      while (seen < idx) begin
         p = p + 1;
         if (!is_pow2(p)) seen = seen + 1;
      end
      return p;
   endfunction

endpackage

// File: rtl/bls_lane_enc.sv
module bls_lane_enc
   import bls_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 4
) (
   input  logic [DW-1:0] d,
   output logic [CW-1:0] c
);

   always_comb begin
      c = '0;
      for (int k = 0; k < CW; k++) begin
         for (int i = 0; i < DW; i++) begin
            if (((data_pos(i) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
         end
      end
   end

endmodule

// File: rtl/bls_lane_dec.sv
module bls_lane_dec
   import bls_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 4
) (
   input  logic [DW-1:0] d,
   input  logic [CW-1:0] c,
   output logic [DW-1:0] fixed,
   output logic [CW-1:0] syn,
   output logic          corr,
   output logic          uncorr
);

   localparam int NPOS = DW + CW;
   localparam logic [CW:0] NPOS_V = (CW + 1)'(NPOS);

   logic [CW-1:0] recomputed;

   bls_lane_enc #(.DW(DW), .CW(CW)) u_recalc (
      .d (d),
      .c (recomputed)
   );

   assign syn = c ^ recomputed;

   always_comb begin
      corr   = (syn != '0) && ({1'b0, syn} <= NPOS_V);
      uncorr = ({1'b0, syn} > NPOS_V);
      for (int i = 0; i < DW; i++) begin
         fixed[i] = d[i] ^ (syn == CW'(data_pos(i)));
      end
   end

endmodule

// File: rtl/bls_out_stage.sv
module bls_out_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_pass
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/bytelane_secc.sv
module bytelane_secc #(
   parameter int LANES   = 2,
   parameter int LANE_W  = 8,
   parameter int CHK_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   output logic [LANES*CHK_W-1:0]    wr_chk,
   input  logic [LANES*LANE_W-1:0]   rd_data,
   input  logic [LANES*CHK_W-1:0]    rd_chk,
   output logic [LANES*LANE_W-1:0]   rd_fixed,
   output logic [LANES*CHK_W-1:0]    rd_syn,
   output logic [LANES-1:0]          rd_corr,
   output logic [LANES-1:0]          rd_uncorr
);

   localparam int DBUS  = LANES * LANE_W;
   localparam int CBUS  = LANES * CHK_W;
   localparam int OUT_W = CBUS + DBUS + CBUS + 2 * LANES;

   // elaboration checks on the parameter set
   generate
      if ((1 << CHK_W) < LANE_W + CHK_W + 1) begin : g_bad_chk
         $error("CHK_W too small to address every codeword position");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_shape
         $error("LANES and LANE_W must be positive");
      end
   endgenerate

   logic [CBUS-1:0]  chk_c;
   logic [DBUS-1:0]  fix_c;
   logic [CBUS-1:0]  syn_c;
   logic [LANES-1:0] corr_c;
   logic [LANES-1:0] unc_c;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         bls_lane_enc #(.DW(LANE_W), .CW(CHK_W)) u_enc (
            .d (wr_data[l*LANE_W +: LANE_W]),
            .c (chk_c[l*CHK_W +: CHK_W])
         );
         bls_lane_dec #(.DW(LANE_W), .CW(CHK_W)) u_dec (
            .d      (rd_data[l*LANE_W +: LANE_W]),
            .c      (rd_chk[l*CHK_W +: CHK_W]),
            .fixed  (fix_c[l*LANE_W +: LANE_W]),
            .syn    (syn_c[l*CHK_W +: CHK_W]),
            .corr   (corr_c[l]),
            .uncorr (unc_c[l])
         );
      end
   endgenerate

   bls_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({chk_c, fix_c, syn_c, corr_c, unc_c}),
      .q     ({wr_chk, rd_fixed, rd_syn, rd_corr, rd_uncorr})
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_chk
         // R8
         excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_corr[l] && rd_uncorr[l]));

         if (OUT_REG) begin : g_reg_props
            // R2
            clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
               ($past(rst_n) && rd_syn[l*CHK_W +: CHK_W] == '0) |->
               (rd_fixed[l*LANE_W +: LANE_W] == $past(rd_data[l*LANE_W +: LANE_W])));
            // R3
            single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $past(rst_n) |->
               ($countones(rd_fixed[l*LANE_W +: LANE_W] ^
                           $past(rd_data[l*LANE_W +: LANE_W])) <= 1));
            // R4
            chk_err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
               ($past(rst_n) && $countones(rd_syn[l*CHK_W +: CHK_W]) == 1) |->
               (rd_fixed[l*LANE_W +: LANE_W] == $past(rd_data[l*LANE_W +: LANE_W])));
            // R6
            uncorr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
               ($past(rst_n) && rd_uncorr[l]) |->
               (rd_fixed[l*LANE_W +: LANE_W] == $past(rd_data[l*LANE_W +: LANE_W])));
         end
      end
   endgenerate

endmodule

// File: tb/bytelane_secc_tb_top.sv
module bytelane_secc_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] wr_data = '0;
   logic [7:0]  wr_chk;
   logic [15:0] rd_data = '0;
   logic [7:0]  rd_chk = '0;
   logic [15:0] rd_fixed;
   logic [7:0]  rd_syn;
   logic [1:0]  rd_corr;
   logic [1:0]  rd_uncorr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bytelane_secc dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data   (wr_data),
      .wr_chk    (wr_chk),
      .rd_data   (rd_data),
      .rd_chk    (rd_chk),
      .rd_fixed  (rd_fixed),
      .rd_syn    (rd_syn),
      .rd_corr   (rd_corr),
      .rd_uncorr (rd_uncorr)
   );

   // ---------------- reference model ----------------
   function automatic int m_pos(input int i);
      case (i)
         0: return 3;  1: return 5;  2: return 6;  3: return 7;
         4: return 9;  5: return 10; 6: return 11; default: return 12;
      endcase
   endfunction

   function automatic logic [3:0] m_enc(input logic [7:0] b);
      logic [3:0] r;
      r = '0;
      for (int i = 0; i < 8; i++)
         for (int k = 0; k < 4; k++)
            if (((m_pos(i) >> k) & 1) == 1) r[k] = r[k] ^ b[i];
      return r;
   endfunction

   function automatic logic [7:0] m_enc16(input logic [15:0] w);
      return {m_enc(w[15:8]), m_enc(w[7:0])};
   endfunction

   task automatic flip(input int lane, input int p,
                       inout logic [15:0] d, inout logic [7:0] c);
      case (p)
         1: c[lane*4 + 0] = ~c[lane*4 + 0];
         2: c[lane*4 + 1] = ~c[lane*4 + 1];
         4: c[lane*4 + 2] = ~c[lane*4 + 2];
         8: c[lane*4 + 3] = ~c[lane*4 + 3];
         default:
            for (int i = 0; i < 8; i++)
               if (m_pos(i) == p) d[lane*8 + i] = ~d[lane*8 + i];
      endcase
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the capturing edge
   task automatic rd_apply(input logic [15:0] d, input logic [7:0] c);
      rd_data = d;
      rd_chk  = c;
      @(posedge clk);
      @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check("R7", "fixed in reset", 32'(rd_fixed), 32'h0);
      check("R7", "syn in reset", 32'(rd_syn), 32'h0);
      check("R7", "flags in reset", 32'({rd_corr, rd_uncorr}), 32'h0);
      check("R7", "wr_chk in reset", 32'(wr_chk), 32'h0);
   endtask

   task automatic t_encode();
      logic [15:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000,
                                16'hA55A, 16'h3CC3, 16'h1234, 16'hFE01};
      foreach (pats[n]) begin
         wr_data = pats[n];
         @(posedge clk);
         @(negedge clk);
         check("R1", "encoded check bits", 32'(wr_chk), 32'(m_enc16(pats[n])));
      end
   endtask

   task automatic t_clean();
      logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h5AC3, 16'h9E27};
      foreach (pats[n]) begin
         rd_apply(pats[n], m_enc16(pats[n]));
         check("R2", "clean data", 32'(rd_fixed), 32'(pats[n]));
         check("R2", "clean syn", 32'(rd_syn), 32'h0);
         check("R2", "clean flags", 32'({rd_corr, rd_uncorr}), 32'h0);
      end
   endtask

   task automatic t_data_flip();
      logic [15:0] w = 16'h5AC3;
      for (int lane = 0; lane < 2; lane++) begin
         for (int i = 0; i < 8; i++) begin
            logic [15:0] d = w;
            logic [7:0]  c = m_enc16(w);
            flip(lane, m_pos(i), d, c);
            rd_apply(d, c);
            check("R3", "data corrected", 32'(rd_fixed), 32'(w));
            check("R3", "syn = position", 32'(rd_syn[lane*4 +: 4]), 32'(m_pos(i)));
            check("R3", "corr flag", 32'(rd_corr), 32'(1 << lane));
            check("R8", "uncorr clear", 32'(rd_uncorr), 32'h0);
         end
      end
   endtask

   task automatic t_chk_flip();
      logic [15:0] w = 16'hC37E;
      int ps [4] = '{1, 2, 4, 8};
      for (int lane = 0; lane < 2; lane++) begin
         foreach (ps[n]) begin
            logic [15:0] d = w;
            logic [7:0]  c = m_enc16(w);
            flip(lane, ps[n], d, c);
            rd_apply(d, c);
            check("R4", "data unchanged", 32'(rd_fixed), 32'(w));
            check("R4", "syn = check pos", 32'(rd_syn[lane*4 +: 4]), 32'(ps[n]));
            check("R4", "corr flag", 32'(rd_corr), 32'(1 << lane));
         end
      end
   endtask

   task automatic t_both_lanes();
      logic [15:0] w = 16'h6B19;
      logic [15:0] d;
      logic [7:0]  c;
      // data error in lane 0, check error in lane 1, same cycle
      d = w; c = m_enc16(w);
      flip(0, 10, d, c);
      flip(1, 8, d, c);
      rd_apply(d, c);
      check("R5", "both lanes fixed", 32'(rd_fixed), 32'(w));
      check("R5", "both syndromes", 32'(rd_syn), 32'h8A);
      check("R5", "both corr", 32'(rd_corr), 32'h3);
      // data errors in both lanes
      d = w; c = m_enc16(w);
      flip(0, 3, d, c);
      flip(1, 12, d, c);
      rd_apply(d, c);
      check("R5", "two data errors fixed", 32'(rd_fixed), 32'(w));
      check("R5", "two data syndromes", 32'(rd_syn), 32'hC3);
      // error only in lane 1 leaves lane 0 untouched
      d = w; c = m_enc16(w);
      flip(1, 6, d, c);
      rd_apply(d, c);
      check("R5", "lane0 data", 32'(rd_fixed[7:0]), 32'(w[7:0]));
      check("R5", "lane0 syn", 32'(rd_syn[3:0]), 32'h0);
      check("R5", "lane0 flags", 32'({rd_corr[0], rd_uncorr[0]}), 32'h0);
      check("R5", "lane1 fixed", 32'(rd_fixed[15:8]), 32'(w[15:8]));
   endtask

   task automatic t_uncorr();
      logic [15:0] w = 16'h3C96;
      logic [3:0]  bad [3] = '{4'd13, 4'd14, 4'd15};
      for (int lane = 0; lane < 2; lane++) begin
         foreach (bad[n]) begin
            logic [15:0] d = w;
            logic [7:0]  c = m_enc16(w);
            c[lane*4 +: 4] = c[lane*4 +: 4] ^ bad[n];
            rd_apply(d, c);
            check("R6", "uncorr flag", 32'(rd_uncorr), 32'(1 << lane));
            check("R6", "corr clear", 32'(rd_corr), 32'h0);
            check("R6", "data passthrough", 32'(rd_fixed), 32'(w));
            check("R6", "syn value", 32'(rd_syn[lane*4 +: 4]), 32'(bad[n]));
         end
      end
   endtask

   task automatic t_latency();
      logic [15:0] a = 16'h0F0F;
      logic [15:0] b = 16'hA55A;
      rd_apply(a, m_enc16(a));
      rd_data = b;
      rd_chk  = m_enc16(b);
      #1;
      check("R7", "old value before edge", 32'(rd_fixed), 32'(a));
      @(posedge clk);
      @(negedge clk);
      check("R7", "new value after edge", 32'(rd_fixed), 32'(b));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_encode();
      t_clean();
      t_data_flip();
      t_chk_flip();
      t_both_lanes();
      t_uncorr();
      t_latency();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule